// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle datapath steered entirely by one 16-bit control word per clock. Each word names a destination register, two source registers, where the second operand comes from, which operation the function unit performs, where the write-back value comes from, and whether the write happens. A whole microoperation, such as reading two registers, adding them and storing the sum, completes in the one clock edge that ends the cycle in which the word is applied.

Inside are eight 16-bit registers with two asynchronous read ports and one synchronous write port. There is a second-operand multiplexer that chooses a register or an external constant. The function unit combines an adder-based arithmetic section, a logic section and a one-place shifter. A write-back multiplexer chooses the function unit result or external input data. The first operand is also driven out as an address, and the second operand as write data, so that a memory can sit beside the block. Four status flags come combinationally from the function unit result of the word currently applied.

The surrounding sequencer that produces control words is not part of this block.

Top module: `cw_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight registers become zero (synchronous, active-low reset).
- R2: Control word fields are: bits [15:13] destination register, [12:10] first-operand register, [9:7] second-operand register, [6] second-operand source, [5:2] function code, [1] write-back source, [0] write enable.
- R3: `addr_out` always equals the register chosen by bits [12:10]. `data_out` equals the register chosen by bits [9:7] when bit 6 is 0, and `const_in` when bit 6 is 1.
- R4: When bit 0 is 1, the write-back value is stored into the register chosen by bits [15:13] at the rising edge, so read, compute and write take exactly one clock cycle.
- R5: When bit 0 is 0, no register changes.
- R6: The write-back value is the function unit result when bit 1 is 0, and `data_in` when bit 1 is 1.
- R7: Arithmetic codes (A is the first operand, B the second): 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A+~B+1 (A−B), 0110 A−1. C is the carry out of bit 15 of that sum, and V is two's-complement overflow.
- R8: Transfer codes: 0000 and 0111 give A, and 1100 gives B.
- R9: Logic codes: 1000 A AND B, 1001 A OR B, 1010 A XOR B, 1011 NOT A.
- R10: Shift codes: 1101 gives B shifted right one place and 1110 gives B shifted left one place, with zero fill in both. Code 1111 gives zero.
- R11: N is bit 15 of the result and Z is 1 when the result is zero. For every code other than 0001 to 0110, V and C are 0. The flags follow the currently applied word without a register.
- R12: When the destination register is also a source, the operation uses the value the register held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Control word for this cycle |
| const_in | input | DATA_W | External constant, second-operand source |
| data_in | input | DATA_W | External data, write-back source |
| addr_out | output | DATA_W | First operand bus |
| data_out | output | DATA_W | Second operand bus |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |

## Verification
The hardest case to reach from the ports is a result that is never shown directly: the function unit output appears only through the flags and through a later readback of the destination register. The stimulus therefore loads a known operand through the external-data path. It then applies each of the sixteen function codes with the second operand taken from the constant input, writes the result to a scratch register, and reads that register back on the first-operand bus in the next cycle. Operand pairs sit at the signed and unsigned edges (0x7FFF, 0x8000, 0xFFFF, zero) so that carry, overflow and zero are each driven both ways. A separate case writes a register from itself to show that the old value is used.

// File: rtl/cwdp_pkg.sv
`timescale 1ns/1ps
// cwdp_pkg: shared constants and types for the control-word datapath.
// Assumes a fixed 16-bit control word with 3-bit register selects.
package cwdp_pkg;
    localparam int SEL_W = 3;
    localparam int FS_W  = 4;
    localparam int CW_W  = 3 * SEL_W + FS_W + 3;

    // Control word fields, most significant first.
    typedef struct packed {
        logic [SEL_W-1:0] dst_sel;
        logic [SEL_W-1:0] a_sel;
        logic [SEL_W-1:0] b_sel;
        logic             b_from_const;
        logic [FS_W-1:0]  func;
        logic             d_from_ext;
        logic             wr_en;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_CLEAR = 2'b11
    } shift_op_e;
endpackage

// File: rtl/cwdp_regbank.sv
`timescale 1ns/1ps
// cwdp_regbank: 2**SEL_W registers, two asynchronous read ports and one
// synchronous write port. Assumes a synchronous active-low reset to zero.
module cwdp_regbank #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_a_sel,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int REG_N = 1 << SEL_W;

    logic [REG_N-1:0][DATA_W-1:0] reg_view;

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_reg
        logic [DATA_W-1:0] q;
        // Hold, clear or load one register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_sel == SEL_W'(gi)))
                q <= wr_data;
        end
        assign reg_view[gi] = q;
    end

    // Asynchronous read ports.
    assign rd_a_data = reg_view[rd_a_sel];
    assign rd_b_data = reg_view[rd_b_sel];
endmodule

// File: rtl/cwdp_alu.sv
`timescale 1ns/1ps
// cwdp_alu: adder-based arithmetic section and bitwise logic section.
// func[3]=0 selects arithmetic: func[2:1] picks the addend (0, B, ~B, ones)
// and func[0] is the carry in. func[3]=1 selects logic by func[1:0].
// Codes 0000 and 0111 are transfers, so carry and overflow are masked.
module cwdp_alu #(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        func,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              ovfl
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] addend;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] logic_res;
    logic              arith_active;

    // Choose the addend for the arithmetic section.
    always_comb begin
        unique case (func[2:1])
            2'b00:   addend = '0;
            2'b01:   addend = op_b;
            2'b10:   addend = ~op_b;
            default: addend = '1;
        endcase
    end

    assign sum = {1'b0, op_a} + {1'b0, addend} + {{DATA_W{1'b0}}, func[0]};

    // Bitwise logic section.
    always_comb begin
        unique case (func[1:0])
            2'b00:   logic_res = op_a & op_b;
            2'b01:   logic_res = op_a | op_b;
            2'b10:   logic_res = op_a ^ op_b;
            default: logic_res = ~op_a;
        endcase
    end

    assign arith_active = !func[3] && (func[2:0] != 3'b000) && (func[2:0] != 3'b111);

    // Select the section output and form carry and overflow.
    always_comb begin
        result = func[3] ? logic_res : sum[MSB:0];
        carry  = arith_active && sum[DATA_W];
        ovfl   = arith_active && (op_a[MSB] == addend[MSB]) && (sum[MSB] != op_a[MSB]);
    end
endmodule

// File: rtl/cwdp_shifter.sv
`timescale 1ns/1ps
// cwdp_shifter: pass, shift right by one, shift left by one, or clear.
// Vacated bits fill with zero.
module cwdp_shifter #(
    parameter int DATA_W = 16
) (
    input  cwdp_pkg::shift_op_e op,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout
);
    import cwdp_pkg::*;

    logic [DATA_W-1:0] right_v;
    logic [DATA_W-1:0] left_v;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        if (gi == DATA_W - 1) begin : g_top
            assign right_v[gi] = 1'b0;
        end else begin : g_mid
            assign right_v[gi] = din[gi+1];
        end
        if (gi == 0) begin : g_bot
            assign left_v[gi] = 1'b0;
        end else begin : g_low
            assign left_v[gi] = din[gi-1];
        end
    end

    // Pick the shifted form.
    always_comb begin
        unique case (op)
            SH_PASS:  dout = din;
            SH_RIGHT: dout = right_v;
            SH_LEFT:  dout = left_v;
            default:  dout = '0;
        endcase
    end
endmodule

// File: rtl/cwdp_func_unit.sv
`timescale 1ns/1ps
// cwdp_func_unit: combines the ALU and the shifter. Codes with func[3:2]=11
// use the shifter on B; all others use the ALU. Produces the V, C, N, Z flags.
module cwdp_func_unit #(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        func,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    output logic              v,
    output logic              c,
    output logic              n,
    output logic              z
);
    import cwdp_pkg::*;

    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] sh_res;
    logic              alu_c;
    logic              alu_v;
    logic              use_shift;

    cwdp_alu #(.DATA_W(DATA_W)) u_alu (
        .func   (func),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (alu_res),
        .carry  (alu_c),
        .ovfl   (alu_v)
    );

    cwdp_shifter #(.DATA_W(DATA_W)) u_shifter (
        .op   (shift_op_e'(func[1:0])),
        .din  (op_b),
        .dout (sh_res)
    );

    assign use_shift = (func[3:2] == 2'b11);

    // Select the unit output and derive the status flags.
    always_comb begin
        result = use_shift ? sh_res : alu_res;
        v      = !use_shift && alu_v;
        c      = !use_shift && alu_c;
        n      = result[DATA_W-1];
        z      = (result == '0);
    end
endmodule

// File: rtl/cw_datapath.sv
`timescale 1ns/1ps
// cw_datapath: single-cycle datapath driven by one control word per clock.
// Assumes the control word is stable around the rising edge; the flags and
// both buses are combinational from the current word and register contents.
module cw_datapath #(
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [cwdp_pkg::CW_W-1:0]  ctrl_word,
    input  logic [DATA_W-1:0]          const_in,
    input  logic [DATA_W-1:0]          data_in,
    output logic [DATA_W-1:0]          addr_out,
    output logic [DATA_W-1:0]          data_out,
    output logic                       flag_v,
    output logic                       flag_c,
    output logic                       flag_n,
    output logic                       flag_z
);
    import cwdp_pkg::*;

    ctrl_word_t        cw;
    logic [DATA_W-1:0] bus_a;
    logic [DATA_W-1:0] reg_b;
    logic [DATA_W-1:0] bus_b;
    logic [DATA_W-1:0] fu_res;
    logic [DATA_W-1:0] bus_d;

    assign cw = ctrl_word_t'(ctrl_word);

    cwdp_regbank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cw.wr_en),
        .wr_sel    (cw.dst_sel),
        .wr_data   (bus_d),
        .rd_a_sel  (cw.a_sel),
        .rd_b_sel  (cw.b_sel),
        .rd_a_data (bus_a),
        .rd_b_data (reg_b)
    );

    // Second-operand source select.
    assign bus_b = cw.b_from_const ? const_in : reg_b;

    cwdp_func_unit #(.DATA_W(DATA_W)) u_func_unit (
        .func   (cw.func),
        .op_a   (bus_a),
        .op_b   (bus_b),
        .result (fu_res),
        .v      (flag_v),
        .c      (flag_c),
        .n      (flag_n),
        .z      (flag_z)
    );

    // Write-back source select.
    assign bus_d = cw.d_from_ext ? data_in : fu_res;

    assign addr_out = bus_a;
    assign data_out = bus_b;
endmodule

// File: rtl/cwdp_checker.sv
`timescale 1ns/1ps
// cwdp_checker: port-level properties of cw_datapath, bound to every instance.
module cwdp_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       ctrl_word,
    input logic [DATA_W-1:0] const_in,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] addr_out,
    input logic [DATA_W-1:0] data_out,
    input logic              flag_v,
    input logic              flag_c,
    input logic              flag_n,
    input logic              flag_z
);
    logic [2:0] dst;
    logic [2:0] asel;
    logic [2:0] bsel;
    logic       mb;
    logic [3:0] fs;
    logic       md;
    logic       wr;

    assign dst  = ctrl_word[15:13];
    assign asel = ctrl_word[12:10];
    assign bsel = ctrl_word[9:7];
    assign mb   = ctrl_word[6];
    assign fs   = ctrl_word[5:2];
    assign md   = ctrl_word[1];
    assign wr   = ctrl_word[0];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0));

    // R4
    ext_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(md) && (asel == $past(dst)))
        |-> (addr_out == $past(data_in)));

    // R5
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr) && (asel == $past(asel)))
        |-> (addr_out == $past(addr_out)));

    // R7
    add_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && !$past(md) && ($past(fs) == 4'b0010)
         && (asel == $past(dst)))
        |-> (addr_out == DATA_W'($past(addr_out) + $past(data_out))));

    // R11
    no_arith_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs[3] || (fs == 4'b0000) || (fs == 4'b0111)) |-> (!flag_v && !flag_c));

    // R11
    pass_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs == 4'b0000) |-> (flag_z == (addr_out == '0)));

    // R8
    pass_const_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb && (fs == 4'b1100))
        |-> ((flag_n == const_in[DATA_W-1]) && (flag_z == (const_in == '0))));

    // R9
    self_xor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mb && (bsel == asel) && (fs == 4'b1010)) |-> flag_z);
endmodule

bind cw_datapath cwdp_checker #(.DATA_W(DATA_W)) u_cwdp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .const_in  (const_in),
    .data_in   (data_in),
    .addr_out  (addr_out),
    .data_out  (data_out),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/test_cw_datapath.sv
`timescale 1ns/1ps
// test_cw_datapath: directed scenarios, one task each, against a bench model.
module test_cw_datapath;
    localparam int  DW       = 16;
    localparam real CLK_HALF = 2.5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   ctrl_word = '0;
    logic [DW-1:0] const_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] addr_out;
    logic [DW-1:0] data_out;
    logic          flag_v, flag_c, flag_n, flag_z;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    cw_datapath #(.DATA_W(DW)) i_cw_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .const_in  (const_in),
        .data_in   (data_in),
        .addr_out  (addr_out),
        .data_out  (data_out),
        .flag_v    (flag_v),
        .flag_c    (flag_c),
        .flag_n    (flag_n),
        .flag_z    (flag_z)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_cw(input int da, input int aa, input int ba,
                                          input bit mb, input int fs, input bit md, input bit rw);
        return {da[2:0], aa[2:0], ba[2:0], mb, fs[3:0], md, rw};
    endfunction

    // Drive a word after the falling edge, then settle before sampling.
    task automatic apply(input logic [15:0] cw, input logic [DW-1:0] cst, input logic [DW-1:0] din);
        @(negedge clk);
        ctrl_word = cw;
        const_in  = cst;
        data_in   = din;
        #1;
    endtask

    task automatic write_ext(input int r, input logic [DW-1:0] val);
        apply(mk_cw(r, 0, 0, 1'b0, 0, 1'b1, 1'b1), '0, val);
    endtask

    task automatic read_reg(input int r, output logic [DW-1:0] val);
        apply(mk_cw(0, r, 0, 1'b0, 0, 1'b0, 1'b0), '0, '0);
        val = addr_out;
    endtask

    // Bench model of the function unit, written from the requirements.
    task automatic ref_fu(input int fs, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          output logic [DW-1:0] r, output bit v, output bit c);
        int ua = int'(a);
        int ub = int'(b);
        int sa = int'($signed(a));
        int sb = int'($signed(b));
        int u = 0;
        int s = 0;
        bit ar = 1'b1;
        case (fs)
            1: begin u = ua + 1;               s = sa + 1;      end
            2: begin u = ua + ub;              s = sa + sb;     end
            3: begin u = ua + ub + 1;          s = sa + sb + 1; end
            4: begin u = ua + (65535 - ub);    s = sa - sb - 1; end
            5: begin u = ua + (65535 - ub) + 1; s = sa - sb;    end
            6: begin u = ua + 65535;           s = sa - 1;      end
            default: ar = 1'b0;
        endcase
        if (ar) begin
            r = u[15:0];
            c = (u > 65535);
            v = (s > 32767) || (s < -32768);
        end else begin
            v = 1'b0;
            c = 1'b0;
            case (fs)
                8:       r = a & b;
                9:       r = a | b;
                10:      r = a ^ b;
                11:      r = ~a;
                12:      r = b;
                13:      r = b >> 1;
                14:      r = b << 1;
                15:      r = '0;
                default: r = a;
            endcase
        end
    endtask

    function automatic string req_of(input int fs);
        if (fs >= 1 && fs <= 6) return "R7";
        if (fs == 0 || fs == 7 || fs == 12) return "R8";
        if (fs >= 8 && fs <= 11) return "R9";
        return "R10";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctrl_word = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset clears every register, even after loads.
    task automatic t_reset();
        logic [DW-1:0] val;
        for (int r = 0; r < 8; r++) write_ext(r, 16'h1111 * (r + 1));
        do_reset();
        for (int r = 0; r < 8; r++) begin
            read_reg(r, val);
            check($sformatf("R1 reg %0d after reset", r), val, '0);
        end
    endtask

    // R6/R4: external data loads each register; readback on the A bus.
    task automatic t_load_all();
        logic [DW-1:0] val;
        for (int r = 0; r < 8; r++) write_ext(r, 16'hA000 + 16'(r * 17));
        for (int r = 0; r < 8; r++) begin
            read_reg(r, val);
            check($sformatf("R6 ext load reg %0d", r), val, 16'hA000 + 16'(r * 17));
        end
    endtask

    // R2/R3/R4: one word does R0 <- R1 + R2 in a single cycle.
    task automatic t_add_single();
        logic [DW-1:0] val;
        write_ext(1, 16'h1234);
        write_ext(2, 16'h0F0F);
        apply(mk_cw(0, 1, 2, 1'b0, 2, 1'b0, 1'b1), 16'hFFFF, 16'hFFFF);
        check("R3 addr_out is A register", addr_out, 16'h1234);
        check("R3 data_out is B register", data_out, 16'h0F0F);
        read_reg(0, val);
        check("R4 R2 single-cycle add result", val, 16'h2143);
    endtask

    // R3: constant drives the B bus and data_out when bit 6 is set.
    task automatic t_const_bus();
        write_ext(4, 16'h00FF);
        apply(mk_cw(7, 3, 4, 1'b1, 12, 1'b0, 1'b0), 16'hC0DE, '0);
        check("R3 data_out follows const_in", data_out, 16'hC0DE);
        apply(mk_cw(7, 3, 4, 1'b0, 12, 1'b0, 1'b0), 16'hC0DE, '0);
        check("R3 data_out follows B register", data_out, 16'h00FF);
    endtask

    // R5: write enable low leaves the destination untouched.
    task automatic t_no_write();
        logic [DW-1:0] val;
        write_ext(4, 16'h5555);
        apply(mk_cw(4, 0, 0, 1'b0, 0, 1'b1, 1'b0), '0, 16'hAAAA);
        read_reg(4, val);
        check("R5 ext data without write enable", val, 16'h5555);
        apply(mk_cw(4, 4, 0, 1'b1, 1, 1'b0, 1'b0), 16'h0001, '0);
        read_reg(4, val);
        check("R5 ALU result without write enable", val, 16'h5555);
    endtask

    // R6: write-back source choice between data_in and function result.
    task automatic t_wb_select();
        logic [DW-1:0] val;
        write_ext(1, 16'h0100);
        apply(mk_cw(6, 1, 0, 1'b1, 2, 1'b1, 1'b1), 16'h0001, 16'h0BAD);
        read_reg(6, val);
        check("R6 write-back from data_in", val, 16'h0BAD);
        apply(mk_cw(6, 1, 0, 1'b1, 2, 1'b0, 1'b1), 16'h0001, 16'h0BAD);
        read_reg(6, val);
        check("R6 write-back from function unit", val, 16'h0101);
    endtask

    // R12: destination equal to source uses the pre-edge value.
    task automatic t_same_reg();
        logic [DW-1:0] val;
        write_ext(5, 16'h4001);
        apply(mk_cw(5, 5, 5, 1'b0, 2, 1'b0, 1'b1), '0, '0);
        check("R11 flags on R5+R5", {12'h0, flag_v, flag_c, flag_n, flag_z}, 16'h000A);
        read_reg(5, val);
        check("R12 R5 <- R5 + R5", val, 16'h8002);
    endtask

    // R7..R11: every function code over edge operand pairs, via R3 scratch.
    task automatic t_func_sweep();
        logic [DW-1:0] pa [5] = '{16'h7FFF, 16'h8000, 16'h0000, 16'h1234, 16'hA5A5};
        logic [DW-1:0] pb [5] = '{16'h0001, 16'h8000, 16'h0000, 16'hFFFF, 16'h5A5A};
        logic [DW-1:0] val, er;
        bit ev, ec;
        for (int p = 0; p < 5; p++) begin
            write_ext(1, pa[p]);
            for (int fs = 0; fs < 16; fs++) begin
                ref_fu(fs, pa[p], pb[p], er, ev, ec);
                apply(mk_cw(3, 1, 0, 1'b1, fs, 1'b0, 1'b1), pb[p], 16'hDEAD);
                check($sformatf("R11 flags code %0d pair %0d", fs, p),
                      {12'h0, flag_v, flag_c, flag_n, flag_z},
                      {12'h0, ev, ec, er[DW-1], (er == '0)});
                read_reg(3, val);
                check($sformatf("%s result code %0d pair %0d", req_of(fs), fs, p), val, er);
            end
        end
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 200000.0);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_load_all();
        t_add_single();
        t_const_bus();
        t_no_write();
        t_wb_select();
        t_same_reg();
        t_func_sweep();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule